// File: doc/BRIEF.md
# Half-Bridge Latched Fault Monitor

This block collects the protection conditions of a half-bridge gate driver and drives an active-low fault indicator that stays latched. Four conditions are watched: supply undervoltage, a lower-side overcurrent comparator flag, an upper-side overcurrent comparator flag, and a disagreement between the commanded output level and the sensed level of the output node. Each raw condition must persist for its own number of consecutive clock cycles before it counts. A qualified undervoltage, lower-side trip or phase disagreement sets the fault latch. The latch pulls the fault indicator low and asserts kill requests to the gate sequencer for both switches.

A qualified upper-side trip does not raise the fault. It switches off only the upper drive, pulse by pulse: the upper kill holds until the next commanded turn-on of the upper switch that arrives while the trip is no longer qualified. The phase comparison is masked while the bridge is disabled and for a blanking window after every change of the command and after every rise of the enable input. This keeps dead time and normal switching edges from being reported as faults.

The latch clears on the asynchronous power-on reset. It also clears when the enable input has been held low without a break for a programmed number of cycles and no source is still qualified. An enable-low interval that ends early restarts the count. A separate select input, which raises the trip threshold, is registered once and passed on to the comparator-threshold control.

Top module: `hb_fault_mon`

## Requirements
- R1: While rst_n is low, and right after it falls even with a fault latched, fault_n is 1, kill_lo is 0, kill_hi is 0 and thr_boost is 0.
- R2: trip_lo high on TRIP_QUAL consecutive rising edges makes fault_n go to 0 one edge later, with kill_lo and kill_hi at 1. A trip_lo run of TRIP_QUAL-1 edges, followed by a low, has no effect.
- R3: trip_hi high on TRIP_QUAL consecutive edges sets kill_hi one edge later and leaves fault_n at 1 and kill_lo at 0. kill_hi stays at 1 after trip_hi falls and after cmd_up falls. It clears on the edge that first sees cmd_up rise while the trip is not qualified.
- R4: uv_flag high on UV_QUAL consecutive edges makes fault_n go to 0 one edge later.
- R5: With enable high and outside blanking, node_hi different from cmd_up on PHASE_QUAL consecutive edges makes fault_n go to 0 one edge later.
- R6: The phase comparison is ignored on the edge where cmd_up changes, or enable rises, and on the next BLANK_CYC edges. It is also ignored whenever enable is low.
- R7: Once latched, fault_n stays at 0 after the source goes away. With enable low on RESET_CYC consecutive edges and no source qualified, fault_n returns to 1 one edge later, and kill_lo and kill_hi return to 0.
- R8: A high on enable before RESET_CYC low edges have passed restarts the count, and the fault stays latched.
- R9: A still-qualified undervoltage keeps fault_n at 0 through any enable-low interval. The latch clears on the second edge after uv_flag falls if the enable-low count has already completed.
- R10: thr_boost equals boost_sel as sampled on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| enable | input | 1 | Bridge enable; held low to clear a latched fault |
| uv_flag | input | 1 | Supply undervoltage flag, 1 = under voltage |
| trip_lo | input | 1 | Lower-side overcurrent comparator flag |
| trip_hi | input | 1 | Upper-side overcurrent comparator flag |
| boost_sel | input | 1 | Trip-threshold raise select |
| cmd_up | input | 1 | Commanded output: 1 = upper switch on (node high), 0 = lower on |
| node_hi | input | 1 | Sensed output node level, 1 = high |
| fault_n | output | 1 | Latched fault indicator, 0 = fault (drives the open-drain pull-down) |
| kill_lo | output | 1 | Request to force the lower drive off |
| kill_hi | output | 1 | Request to force the upper drive off |
| thr_boost | output | 1 | Registered threshold-raise control to the comparators |

## Verification
Each result is due a fixed number of edges after its stimulus. A trip or undervoltage appears on fault_n after its qualify length plus one edge. A phase disagreement that begins with a command change appears after BLANK_CYC+1+PHASE_QUAL+1 edges. A clear appears after RESET_CYC+1 enable-low edges, and thr_boost appears after one edge. The bench applies every input at a falling edge and counts the rising edges itself. It samples at the falling edge that follows, both on the last edge where the old value must still hold and on the edge where the new value is due. The exact boundary of every window is therefore checked from both sides.

// File: rtl/hb_fault_pkg.sv
package hb_fault_pkg;

  // Indices of the qualified protection sources
  typedef enum int {
    SRC_UV = 0,
    SRC_LO = 1,
    SRC_HI = 2,
    SRC_PH = 3
  } src_e;

  localparam int NSRC = 4;

  // Counter width able to hold the value n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Persistence length per source
  function automatic int qual_len(input int idx, input int uvq,
                                  input int trq, input int phq);
    case (idx)
      SRC_UV:  return uvq;
      SRC_PH:  return phq;
      default: return trq;
    endcase
  endfunction

endpackage

// File: rtl/hb_qual.sv
module hb_qual #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic q
);
  import hb_fault_pkg::*;

  localparam int W = cnt_w(LEN);
  localparam logic [W-1:0] LEN_V = W'(LEN);

  logic [W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (!raw)           run_cnt <= '0;
    else if (run_cnt != LEN_V) run_cnt <= run_cnt + 1'b1;
  end

  assign q = (run_cnt == LEN_V);

  AST_QUAL_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(raw)); // R2

endmodule

// File: rtl/hb_phase_mask.sv
module hb_phase_mask #(
  parameter int BLANK_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cmd_up,
  input  logic node_hi,
  output logic mism_raw,
  output logic cmd_rise
);
  import hb_fault_pkg::*;

  localparam int BW = cnt_w(BLANK_CYC);
  localparam logic [BW-1:0] BLANK_V = BW'(BLANK_CYC);

  logic          cmd_q;
  logic          en_q;
  logic [BW-1:0] bcnt;
  logic          edge_evt;
  logic          blank_on;

  assign edge_evt = (cmd_up != cmd_q) || (enable && !en_q);
  assign cmd_rise = cmd_up && !cmd_q;
  assign blank_on = edge_evt || (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      en_q  <= 1'b0;
      bcnt  <= '0;
    end else begin
      cmd_q <= cmd_up;
      en_q  <= enable;
      if (edge_evt)         bcnt <= BLANK_V;
      else if (bcnt != '0)  bcnt <= bcnt - 1'b1;
    end
  end

  assign mism_raw = enable && !blank_on && (node_hi != cmd_up);

  AST_MASK_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cmd_up) |=> !mism_raw); // R6

  AST_MASK_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !mism_raw); // R6

endmodule

// File: rtl/hb_clr_timer.sv
module hb_clr_timer #(
  parameter int RESET_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic clr
);
  import hb_fault_pkg::*;

  localparam int RW = cnt_w(RESET_CYC);
  localparam logic [RW-1:0] RMAX = RW'(RESET_CYC);

  logic [RW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_cnt <= '0;
    else if (enable)          low_cnt <= '0;
    else if (low_cnt != RMAX) low_cnt <= low_cnt + 1'b1;
  end

  assign clr = (low_cnt == RMAX);

  AST_EN_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !clr); // R8

endmodule

// File: rtl/hb_fault_mon.sv
module hb_fault_mon #(
  parameter int UV_QUAL    = 16,
  parameter int TRIP_QUAL  = 375,
  parameter int PHASE_QUAL = 88,
  parameter int BLANK_CYC  = 40,
  parameter int RESET_CYC  = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic uv_flag,
  input  logic trip_lo,
  input  logic trip_hi,
  input  logic boost_sel,
  input  logic cmd_up,
  input  logic node_hi,
  output logic fault_n,
  output logic kill_lo,
  output logic kill_hi,
  output logic thr_boost
);
  import hb_fault_pkg::*;

  logic [NSRC-1:0] src_raw;
  logic [NSRC-1:0] src_q;
  logic            mism_raw;
  logic            cmd_rise;
  logic            clr;
  logic            set_lat;
  logic            fault_lat;
  logic            hi_kill;
  logic            boost_q;

  hb_phase_mask #(.BLANK_CYC(BLANK_CYC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cmd_up   (cmd_up),
    .node_hi  (node_hi),
    .mism_raw (mism_raw),
    .cmd_rise (cmd_rise)
  );

  assign src_raw[SRC_UV] = uv_flag;
  assign src_raw[SRC_LO] = trip_lo;
  assign src_raw[SRC_HI] = trip_hi;
  assign src_raw[SRC_PH] = mism_raw;

  for (genvar g = 0; g < NSRC; g++) begin : g_qual
    hb_qual #(.LEN(qual_len(g, UV_QUAL, TRIP_QUAL, PHASE_QUAL))) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (src_raw[g]),
      .q     (src_q[g])
    );
  end

  hb_clr_timer #(.RESET_CYC(RESET_CYC)) u_clr (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .clr    (clr)
  );

  // Latching sources; setting wins over clearing
  assign set_lat = src_q[SRC_UV] | src_q[SRC_LO] | src_q[SRC_PH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_lat <= 1'b0;
      hi_kill   <= 1'b0;
      boost_q   <= 1'b0;
    end else begin
      fault_lat <= set_lat | (fault_lat & ~clr);
      if (src_q[SRC_HI])  hi_kill <= 1'b1;
      else if (cmd_rise)  hi_kill <= 1'b0;
      boost_q <= boost_sel;
    end
  end

  assign fault_n   = ~fault_lat;
  assign kill_lo   = fault_lat;
  assign kill_hi   = fault_lat | hi_kill;
  assign thr_boost = boost_q;

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(src_q[SRC_UV] | src_q[SRC_LO] | src_q[SRC_PH])); // R2

  AST_CLEAR_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(clr) && !$past(enable)); // R7

  AST_UV_KEEPS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    src_q[SRC_UV] |=> !fault_n); // R9

  AST_HI_TRIP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    src_q[SRC_HI] |=> kill_hi); // R3

endmodule

// File: tb/sim_hb_fault_mon.sv
module sim_hb_fault_mon;

  localparam int UQ = 16;
  localparam int TQ = 375;
  localparam int PQ = 88;
  localparam int BL = 40;
  localparam int RC = 500;

  typedef struct packed {
    logic        uv, lo, hi, bo, cm, nd, en;
    logic [15:0] h;
    logic        efn, eklo, ekhi, ebo;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 36;
  // fields: uv lo hi bo cmd node en | hold edges | fault_n kill_lo kill_hi boost | req
  localparam vec_t TBL [NV] = '{
    '{0,0,0,0,0,0,1, BL+10,   1,0,0,0, 1},  // R1 idle
    '{0,0,0,1,0,0,1, 1,       1,0,0,1, 10}, // R10 boost one edge
    '{0,0,0,0,0,0,1, 1,       1,0,0,0, 10}, // R10
    '{0,1,0,0,0,0,1, TQ-1,    1,0,0,0, 2},  // R2 short trip
    '{0,0,0,0,0,0,1, 2,       1,0,0,0, 2},  // R2 no effect
    '{0,1,0,0,0,0,1, TQ,      1,0,0,0, 2},  // R2 last edge before
    '{0,1,0,0,0,0,1, 1,       0,1,1,0, 2},  // R2 due
    '{0,0,0,0,0,0,1, 20,      0,1,1,0, 7},  // R7 latched
    '{0,0,0,0,0,0,0, RC,      0,1,1,0, 7},  // R7 not yet
    '{0,0,0,0,0,0,0, 1,       1,0,0,0, 7},  // R7 cleared
    '{0,0,0,0,0,0,1, BL+5,    1,0,0,0, 6},  // R6 enable rise
    '{0,0,0,0,1,1,1, BL+5,    1,0,0,0, 6},  // R6 cmd edge
    '{0,0,1,0,1,1,1, TQ,      1,0,0,0, 3},  // R3 before
    '{0,0,1,0,1,1,1, 1,       1,0,1,0, 3},  // R3 upper kill
    '{0,0,0,0,1,1,1, 5,       1,0,1,0, 3},  // R3 holds
    '{0,0,0,0,0,0,1, BL+5,    1,0,1,0, 3},  // R3 fall keeps
    '{0,0,0,0,1,1,1, 1,       1,0,0,0, 3},  // R3 rise clears
    '{0,0,0,0,1,1,1, BL+5,    1,0,0,0, 5},  // R5 settle
    '{0,0,0,0,1,0,1, PQ,      1,0,0,0, 5},  // R5 before
    '{0,0,0,0,1,0,1, 1,       0,1,1,0, 5},  // R5 due
    '{0,0,0,0,1,1,0, RC+1,    1,0,0,0, 7},  // R7 clear
    '{0,0,0,0,1,1,1, BL+5,    1,0,0,0, 6},  // R6 settle
    '{0,0,0,0,0,1,1, BL+PQ+1, 1,0,0,0, 6},  // R6 blank window edge
    '{0,0,0,0,0,1,1, 1,       0,1,1,0, 6},  // R6 due
    '{1,0,0,0,0,0,0, RC+5,    0,1,1,0, 9},  // R9 uv holds
    '{0,0,0,0,0,0,0, 1,       0,1,1,0, 9},  // R9 first edge
    '{0,0,0,0,0,0,0, 1,       1,0,0,0, 9},  // R9 second edge
    '{0,0,0,0,0,0,1, BL+5,    1,0,0,0, 4},  // R4 settle
    '{1,0,0,0,0,0,1, UQ,      1,0,0,0, 4},  // R4 before
    '{1,0,0,0,0,0,1, 1,       0,1,1,0, 4},  // R4 due
    '{0,0,0,0,0,0,1, 3,       0,1,1,0, 8},  // R8
    '{0,0,0,0,0,0,0, RC-1,    0,1,1,0, 8},  // R8 partial
    '{0,0,0,0,0,0,1, 1,       0,1,1,0, 8},  // R8 break
    '{0,0,0,0,0,0,0, RC-1,    0,1,1,0, 8},  // R8 restarted
    '{0,0,0,0,0,0,0, 2,       1,0,0,0, 8},  // R8 completes
    '{0,0,0,0,1,0,0, BL+PQ+10,1,0,0,0, 6}   // R6 disabled mask
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, uv_flag = 1'b0, trip_lo = 1'b0, trip_hi = 1'b0;
  logic boost_sel = 1'b0, cmd_up = 1'b0, node_hi = 1'b0;
  logic fault_n, kill_lo, kill_hi, thr_boost;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_fault_mon #(.UV_QUAL(UQ), .TRIP_QUAL(TQ), .PHASE_QUAL(PQ),
                 .BLANK_CYC(BL), .RESET_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .uv_flag(uv_flag),
    .trip_lo(trip_lo), .trip_hi(trip_hi), .boost_sel(boost_sel),
    .cmd_up(cmd_up), .node_hi(node_hi), .fault_n(fault_n),
    .kill_lo(kill_lo), .kill_hi(kill_hi), .thr_boost(thr_boost)
  );

  task automatic check(input int rq, input logic [3:0] exp);
    logic [3:0] act;
    act = {fault_n, kill_lo, kill_hi, thr_boost};
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d: {fault_n,kill_lo,kill_hi,thr_boost} actual=%b expected=%b",
               rq, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 4'b1000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {uv_flag, trip_lo, trip_hi, boost_sel, cmd_up, node_hi, enable} =
        {TBL[i].uv, TBL[i].lo, TBL[i].hi, TBL[i].bo, TBL[i].cm, TBL[i].nd, TBL[i].en};
      repeat (int'(TBL[i].h)) @(posedge clk);
      @(negedge clk);
      check(int'(TBL[i].rq), {TBL[i].efn, TBL[i].eklo, TBL[i].ekhi, TBL[i].ebo});
    end

    // R1: reset while a lower-trip fault is latched
    {uv_flag, trip_lo, trip_hi, boost_sel, cmd_up, node_hi, enable} = 7'b0000001;
    repeat (BL + 5) @(posedge clk);
    @(negedge clk);
    trip_lo = 1'b1;
    boost_sel = 1'b1;
    repeat (TQ + 1) @(posedge clk);
    @(negedge clk);
    check(2, 4'b0111);
    rst_n = 1'b0;
    #1;
    check(1, 4'b1000);
    trip_lo = 1'b0;
    boost_sel = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 4'b1000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule